// File: doc/BRIEF.md
# Operand Bypass and Load-Use Hazard Control

This block is the data-hazard controller for a five-stage in-order pipeline with eight architectural registers and a small load/store instruction set. Each cycle it looks at the register fields, opcodes and valid flags held in the decode stage, in the execute stage (the ID/EX register) and in the three later pipeline registers (EX/MEM, MEM/WB and a post-writeback WB/END register). From these it works out where each ALU operand of the instruction in execute must come from.

Every pairing of an operand with a later stage is compared on its own. Each operand then gets its own bypass select: the register-file value or one of the three later stages. The block also detects a load in execute whose destination feeds the instruction in decode. Forwarding cannot cover that case, so the block holds the PC and the IF/ID register through their enables and injects a noop into ID/EX for one cycle. A parameter states whether the register file already passes a same-cycle write through to a read. In that mode the WB/END path is never used. The block has no state: every output follows its inputs within the same cycle.

Top module: `hz_fwd_unit`

## Requirements
- R1: Opcodes are 3 bits: add=000, nor=001, lw=010, sw=011, beq=100, noop=111; 101 and 110 are reserved and neither read nor write registers. add and nor write the register in their third (rd) field, lw writes the register in its second (rb) field, and no other opcode writes a register.
- R2: A bypass select is 2 bits: 00 register file, 01 EX/MEM, 10 MEM/WB, 11 WB/END.
- R3: Operand A of the instruction in execute (used by add, nor, lw, sw and beq) is bypassed from a later stage that writes the register named in its ra field.
- R4: Operand B (used by add, nor, sw and beq) is bypassed the same way on its rb field; for lw, and for any opcode that does not read B, the B select is 00.
- R5: When several later stages write the matching register, the youngest wins: EX/MEM over MEM/WB over WB/END.
- R6: A stage whose valid flag is low, or whose opcode writes no register, is never chosen. An invalid execute stage gives 00 on both selects.
- R7: When a valid lw sits in execute and a valid decode instruction reads its destination as operand A or operand B, pc_en and ifid_en go low and idex_bubble goes high in the same cycle.
- R8: No stall is raised when the execute instruction is not a valid lw, or when the decode stage is invalid; pc_en=1, ifid_en=1 and idex_bubble=0 then.
- R9: With RF_WRITE_THROUGH=1 the select 11 (WB/END) never appears, and a match only in WB/END gives 00.
- R10: The two operand selects are decided independently, so operand A and operand B may come from different stages in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_valid | input | 1 | Decode stage holds a live instruction |
| id_op | input | 3 | Decode opcode |
| id_ra | input | 3 | Decode first register field |
| id_rb | input | 3 | Decode second register field |
| ex_valid | input | 1 | ID/EX holds a live instruction |
| ex_op | input | 3 | ID/EX opcode |
| ex_ra | input | 3 | ID/EX first register field |
| ex_rb | input | 3 | ID/EX second register field |
| exmem_valid | input | 1 | EX/MEM holds a live instruction |
| exmem_op | input | 3 | EX/MEM opcode |
| exmem_rb | input | 3 | EX/MEM second register field |
| exmem_rd | input | 3 | EX/MEM third register field |
| memwb_valid | input | 1 | MEM/WB holds a live instruction |
| memwb_op | input | 3 | MEM/WB opcode |
| memwb_rb | input | 3 | MEM/WB second register field |
| memwb_rd | input | 3 | MEM/WB third register field |
| wbend_valid | input | 1 | WB/END holds a live instruction |
| wbend_op | input | 3 | WB/END opcode |
| wbend_rb | input | 3 | WB/END second register field |
| wbend_rd | input | 3 | WB/END third register field |
| fwd_a_sel | output | 2 | Bypass select for ALU operand A |
| fwd_b_sel | output | 2 | Bypass select for ALU operand B |
| pc_en | output | 1 | PC load enable (low while stalling) |
| ifid_en | output | 1 | IF/ID load enable (low while stalling) |
| idex_bubble | output | 1 | Load a noop into ID/EX |

## Verification
All results are combinational: both selects and the three stall outputs settle in the same cycle in which the pipeline-register fields are presented, with no register on the way. The bench changes the inputs just after a rising edge and samples at the following falling edge, half a period later, so each vector is checked within its own cycle and never against a neighbour's values. A second instance with register-file write-through enabled sees the same stimulus, so both forwarding modes are checked against the same vector.

// File: rtl/hz_pkg.sv
package hz_pkg;

    localparam int OP_W  = 3;
    localparam int SEL_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD  = 3'd0,
        OP_NOR  = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_RSV5 = 3'd5,
        OP_RSV6 = 3'd6,
        OP_NOOP = 3'd7
    } opcode_e;

    typedef enum logic [SEL_W-1:0] {
        SRC_RF    = 2'd0,
        SRC_EXMEM = 2'd1,
        SRC_MEMWB = 2'd2,
        SRC_WBEND = 2'd3
    } opnd_src_e;

    // Opcode writes a register at all
    function automatic logic op_writes(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_NOR) || (op == OP_LW);
    endfunction

    // Destination lives in the rb field (load) rather than rd
    function automatic logic op_dest_in_rb(input logic [OP_W-1:0] op);
        return (op == OP_LW);
    endfunction

    function automatic logic op_reads_a(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_NOR) || (op == OP_LW) ||
               (op == OP_SW)  || (op == OP_BEQ);
    endfunction

    function automatic logic op_reads_b(input logic [OP_W-1:0] op);
        return (op == OP_ADD) || (op == OP_NOR) ||
               (op == OP_SW)  || (op == OP_BEQ);
    endfunction

endpackage

// File: rtl/hz_producer.sv
module hz_producer
    import hz_pkg::*;
#(
    parameter int REG_W = 3
) (
    input  logic               valid,
    input  logic [OP_W-1:0]    op,
    input  logic [REG_W-1:0]   rb,
    input  logic [REG_W-1:0]   rd,
    input  logic               path_on,
    output logic               wr_en,
    output logic [REG_W-1:0]   wr_reg
);
    always_comb begin
        wr_en  = path_on && valid && op_writes(op);
        wr_reg = op_dest_in_rb(op) ? rb : rd;
    end
endmodule

// File: rtl/hz_src_select.sv
module hz_src_select
    import hz_pkg::*;
#(
    parameter int REG_W   = 3,
    parameter int NUM_SRC = 3
) (
    input  logic                       need,
    input  logic [REG_W-1:0]           src_reg,
    input  logic [NUM_SRC-1:0]         prod_en,
    input  logic [NUM_SRC*REG_W-1:0]   prod_reg,
    output opnd_src_e                  sel
);
    logic [NUM_SRC-1:0] hit;

    // One comparator per stage, kept apart so each picks its own path
    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cmp
        assign hit[s] = need && prod_en[s] &&
                        (prod_reg[s*REG_W +: REG_W] == src_reg);
    end

    // Walk oldest to youngest so the youngest match is written last
    always_comb begin
        sel = SRC_RF;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (hit[i]) sel = opnd_src_e'(SEL_W'(i + 1));
        end
    end
endmodule

// File: rtl/hz_load_use.sv
module hz_load_use
    import hz_pkg::*;
#(
    parameter int REG_W = 3
) (
    input  logic               ex_valid,
    input  logic [OP_W-1:0]    ex_op,
    input  logic [REG_W-1:0]   ex_rb,
    input  logic               id_valid,
    input  logic [OP_W-1:0]    id_op,
    input  logic [REG_W-1:0]   id_ra,
    input  logic [REG_W-1:0]   id_rb,
    output logic               stall
);
    logic load_in_ex;
    logic dep_a;
    logic dep_b;

    always_comb begin
        load_in_ex = ex_valid && (ex_op == OP_LW);
        dep_a      = op_reads_a(id_op) && (id_ra == ex_rb);
        dep_b      = op_reads_b(id_op) && (id_rb == ex_rb);
        stall      = load_in_ex && id_valid && (dep_a || dep_b);
    end
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
    import hz_pkg::*;
#(
    parameter int REG_W            = 3,
    parameter bit RF_WRITE_THROUGH = 1'b0
) (
    input  logic               id_valid,
    input  logic [2:0]         id_op,
    input  logic [REG_W-1:0]   id_ra,
    input  logic [REG_W-1:0]   id_rb,
    input  logic               ex_valid,
    input  logic [2:0]         ex_op,
    input  logic [REG_W-1:0]   ex_ra,
    input  logic [REG_W-1:0]   ex_rb,
    input  logic               exmem_valid,
    input  logic [2:0]         exmem_op,
    input  logic [REG_W-1:0]   exmem_rb,
    input  logic [REG_W-1:0]   exmem_rd,
    input  logic               memwb_valid,
    input  logic [2:0]         memwb_op,
    input  logic [REG_W-1:0]   memwb_rb,
    input  logic [REG_W-1:0]   memwb_rd,
    input  logic               wbend_valid,
    input  logic [2:0]         wbend_op,
    input  logic [REG_W-1:0]   wbend_rb,
    input  logic [REG_W-1:0]   wbend_rd,
    output logic [1:0]         fwd_a_sel,
    output logic [1:0]         fwd_b_sel,
    output logic               pc_en,
    output logic               ifid_en,
    output logic               idex_bubble
);
    localparam int NUM_SRC = 3;
    localparam int NUM_OPN = 2;

    // Later stages packed youngest first: 0 EX/MEM, 1 MEM/WB, 2 WB/END
    logic [NUM_SRC-1:0]          st_valid;
    logic [NUM_SRC*OP_W-1:0]     st_op;
    logic [NUM_SRC*REG_W-1:0]    st_rb;
    logic [NUM_SRC*REG_W-1:0]    st_rd;
    logic [NUM_SRC-1:0]          prod_en;
    logic [NUM_SRC*REG_W-1:0]    prod_reg;

    assign st_valid = {wbend_valid, memwb_valid, exmem_valid};
    assign st_op    = {wbend_op, memwb_op, exmem_op};
    assign st_rb    = {wbend_rb, memwb_rb, exmem_rb};
    assign st_rd    = {wbend_rd, memwb_rd, exmem_rd};

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_prod
        logic path_on;
        if (s == NUM_SRC - 1) begin : g_last
            // Post-writeback path only when the register file lacks write-through
            assign path_on = !RF_WRITE_THROUGH;
        end else begin : g_mid
            assign path_on = 1'b1;
        end
        hz_producer #(.REG_W(REG_W)) u_prod (
            .valid   (st_valid[s]),
            .op      (st_op[s*OP_W +: OP_W]),
            .rb      (st_rb[s*REG_W +: REG_W]),
            .rd      (st_rd[s*REG_W +: REG_W]),
            .path_on (path_on),
            .wr_en   (prod_en[s]),
            .wr_reg  (prod_reg[s*REG_W +: REG_W])
        );
    end

    // Operand 0 is A (ra field), operand 1 is B (rb field)
    logic [NUM_OPN-1:0]          opn_need;
    logic [NUM_OPN*REG_W-1:0]    opn_reg;
    opnd_src_e                   opn_sel [NUM_OPN];

    assign opn_need = {ex_valid && op_reads_b(ex_op), ex_valid && op_reads_a(ex_op)};
    assign opn_reg  = {ex_rb, ex_ra};

    for (genvar g = 0; g < NUM_OPN; g++) begin : g_opn
        hz_src_select #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_sel (
            .need     (opn_need[g]),
            .src_reg  (opn_reg[g*REG_W +: REG_W]),
            .prod_en  (prod_en),
            .prod_reg (prod_reg),
            .sel      (opn_sel[g])
        );
    end

    assign fwd_a_sel = opn_sel[0];
    assign fwd_b_sel = opn_sel[1];

    logic stall;

    hz_load_use #(.REG_W(REG_W)) u_lu (
        .ex_valid (ex_valid),
        .ex_op    (ex_op),
        .ex_rb    (ex_rb),
        .id_valid (id_valid),
        .id_op    (id_op),
        .id_ra    (id_ra),
        .id_rb    (id_rb),
        .stall    (stall)
    );

    assign pc_en       = !stall;
    assign ifid_en     = !stall;
    assign idex_bubble = stall;

    always_comb begin
        // R6
        idle_ex_chk: assert (ex_valid || (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0))
            else $error("select active with empty execute stage");
        // R4
        lw_no_b_chk: assert (!(ex_op == OP_LW) || fwd_b_sel == 2'd0)
            else $error("load given an operand B bypass");
        // R9
        no_wbend_chk: assert (!RF_WRITE_THROUGH || (fwd_a_sel != 2'd3 && fwd_b_sel != 2'd3))
            else $error("post-writeback path used with write-through file");
        // R8
        no_stall_chk: assert ((ex_valid && ex_op == OP_LW && id_valid) || (pc_en && ifid_en && !idex_bubble))
            else $error("stall without a load in execute");
        // R5
        young_a_chk: assert (!(ex_valid && op_reads_a(ex_op) && exmem_valid &&
                               op_writes(exmem_op) &&
                               ((exmem_op == OP_LW ? exmem_rb : exmem_rd) == ex_ra))
                             || fwd_a_sel == 2'd1)
            else $error("EX/MEM match not preferred for operand A");
    end
endmodule

// File: tb/hz_fwd_unit_tb.sv
module hz_fwd_unit_tb;
    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       id_valid, ex_valid, exmem_valid, memwb_valid, wbend_valid;
    logic [2:0] id_op, id_ra, id_rb, ex_op, ex_ra, ex_rb;
    logic [2:0] exmem_op, exmem_rb, exmem_rd, memwb_op, memwb_rb, memwb_rd;
    logic [2:0] wbend_op, wbend_rb, wbend_rd;
    logic [1:0] a0, b0, a1, b1;
    logic       pc0, if0, bub0, pc1, if1, bub1;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    hz_fwd_unit #(.RF_WRITE_THROUGH(1'b0)) u_dut (
        .id_valid, .id_op, .id_ra, .id_rb, .ex_valid, .ex_op, .ex_ra, .ex_rb,
        .exmem_valid, .exmem_op, .exmem_rb, .exmem_rd,
        .memwb_valid, .memwb_op, .memwb_rb, .memwb_rd,
        .wbend_valid, .wbend_op, .wbend_rb, .wbend_rd,
        .fwd_a_sel(a0), .fwd_b_sel(b0), .pc_en(pc0), .ifid_en(if0), .idex_bubble(bub0)
    );

    hz_fwd_unit #(.RF_WRITE_THROUGH(1'b1)) u_dut_wt (
        .id_valid, .id_op, .id_ra, .id_rb, .ex_valid, .ex_op, .ex_ra, .ex_rb,
        .exmem_valid, .exmem_op, .exmem_rb, .exmem_rd,
        .memwb_valid, .memwb_op, .memwb_rb, .memwb_rd,
        .wbend_valid, .wbend_op, .wbend_rb, .wbend_rd,
        .fwd_a_sel(a1), .fwd_b_sel(b1), .pc_en(pc1), .ifid_en(if1), .idex_bubble(bub1)
    );

    // Reference model written from the requirements (R1)
    function automatic bit m_wr(input logic [2:0] op);
        return op == 3'd0 || op == 3'd1 || op == 3'd2;
    endfunction
    function automatic bit m_ra(input logic [2:0] op);
        return op <= 3'd4;
    endfunction
    function automatic bit m_rb(input logic [2:0] op);
        return op == 3'd0 || op == 3'd1 || op == 3'd3 || op == 3'd4;
    endfunction
    function automatic logic [2:0] m_dst(input logic [2:0] op, input logic [2:0] rb,
                                         input logic [2:0] rd);
        return (op == 3'd2) ? rb : rd;
    endfunction

    function automatic logic [1:0] m_sel(input bit need, input logic [2:0] r, input bit wt);
        logic [1:0] s = 2'd0;
        if (!need || !ex_valid) return 2'd0;
        if (!wt && wbend_valid && m_wr(wbend_op) && m_dst(wbend_op, wbend_rb, wbend_rd) == r) s = 2'd3;
        if (memwb_valid && m_wr(memwb_op) && m_dst(memwb_op, memwb_rb, memwb_rd) == r) s = 2'd2;
        if (exmem_valid && m_wr(exmem_op) && m_dst(exmem_op, exmem_rb, exmem_rd) == r) s = 2'd1;
        return s;
    endfunction

    function automatic bit m_stall();
        return ex_valid && ex_op == 3'd2 && id_valid &&
               ((m_ra(id_op) && id_ra == ex_rb) || (m_rb(id_op) && id_rb == ex_rb));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Full comparison of both instances against the model, sampled mid-cycle
    task automatic check_all(input string req);
        bit st;
        @(negedge clk);
        st = m_stall();
        chk({req, " A sel"}, 32'(a0), 32'(m_sel(m_ra(ex_op), ex_ra, 1'b0)));
        chk({req, " B sel"}, 32'(b0), 32'(m_sel(m_rb(ex_op), ex_rb, 1'b0)));
        chk({req, " R9 A sel wt"}, 32'(a1), 32'(m_sel(m_ra(ex_op), ex_ra, 1'b1)));
        chk({req, " R9 B sel wt"}, 32'(b1), 32'(m_sel(m_rb(ex_op), ex_rb, 1'b1)));
        chk({req, " stall"}, {29'd0, pc0, if0, bub0}, {29'd0, !st, !st, st});
        chk({req, " stall wt"}, {29'd0, pc1, if1, bub1}, {29'd0, !st, !st, st});
    endtask

    task automatic clear_all();
        @(posedge clk);
        #1;
        {id_valid, ex_valid, exmem_valid, memwb_valid, wbend_valid} = '0;
        {id_op, ex_op, exmem_op, memwb_op, wbend_op} = {5{3'd7}};
        {id_ra, id_rb, ex_ra, ex_rb} = '0;
        {exmem_rb, exmem_rd, memwb_rb, memwb_rd, wbend_rb, wbend_rd} = '0;
    endtask

    task automatic set_ex(input logic [2:0] op, input logic [2:0] ra, input logic [2:0] rb);
        ex_valid = 1'b1; ex_op = op; ex_ra = ra; ex_rb = rb;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        clear_all();
        // R6 R8: everything empty
        check_all("R6 R8 idle");
        chk("R2 idle A is register file", 32'(a0), 32'd0);
        chk("R8 idle pc_en", 32'(pc0), 32'd1);

        // R3: EX/MEM add writes r3, execute add reads r3 on A
        clear_all(); set_ex(3'd0, 3'd3, 3'd1);
        exmem_valid = 1; exmem_op = 3'd0; exmem_rd = 3'd3;
        check_all("R3 exmem");
        chk("R3 A from EX/MEM", 32'(a0), 32'd1);

        // R5: three producers of r3
        memwb_valid = 1; memwb_op = 3'd1; memwb_rd = 3'd3;
        wbend_valid = 1; wbend_op = 3'd0; wbend_rd = 3'd3;
        check_all("R5 three");
        chk("R5 youngest EX/MEM", 32'(a0), 32'd1);
        exmem_valid = 0;
        check_all("R5 two");
        chk("R5 MEM/WB over WB/END", 32'(a0), 32'd2);
        memwb_valid = 0;
        check_all("R5 one");
        chk("R5 WB/END only", 32'(a0), 32'd3);
        chk("R9 write-through ignores WB/END", 32'(a1), 32'd0);

        // R4: lw in execute reads only A
        clear_all(); set_ex(3'd2, 3'd1, 3'd3);
        memwb_valid = 1; memwb_op = 3'd0; memwb_rd = 3'd3;
        check_all("R4 lw");
        chk("R4 lw B stays 00", 32'(b0), 32'd0);

        // R1: lw producer writes its rb field
        clear_all(); set_ex(3'd0, 3'd5, 3'd2);
        memwb_valid = 1; memwb_op = 3'd2; memwb_rb = 3'd5; memwb_rd = 3'd2;
        check_all("R1 lw dest");
        chk("R1 lw dest rb gives A", 32'(a0), 32'd2);
        chk("R1 lw rd not a dest", 32'(b0), 32'd0);

        // R6: sw producer and invalid producer
        clear_all(); set_ex(3'd0, 3'd4, 3'd4);
        exmem_valid = 1; exmem_op = 3'd3; exmem_rb = 3'd4; exmem_rd = 3'd4;
        memwb_valid = 0; memwb_op = 3'd0; memwb_rd = 3'd4;
        check_all("R6 non-writer");
        chk("R6 sw and invalid ignored", 32'({a0, b0}), 32'd0);

        // R10: A from EX/MEM, B from WB/END
        clear_all(); set_ex(3'd1, 3'd1, 3'd2);
        exmem_valid = 1; exmem_op = 3'd0; exmem_rd = 3'd1;
        wbend_valid = 1; wbend_op = 3'd1; wbend_rd = 3'd2;
        check_all("R10 split");
        chk("R10 A=01 B=11", 32'({a0, b0}), 32'b0111);

        // R7: load-use on A, on B, store data, and lw whose rb is its own dest
        clear_all(); set_ex(3'd2, 3'd0, 3'd6);
        id_valid = 1; id_op = 3'd0; id_ra = 3'd6; id_rb = 3'd1;
        check_all("R7 use A");
        chk("R7 stall on A", 32'({pc0, if0, bub0}), 32'b001);
        id_ra = 3'd1; id_rb = 3'd6;
        check_all("R7 use B");
        chk("R7 stall on B", 32'({pc0, if0, bub0}), 32'b001);
        id_op = 3'd3;
        check_all("R7 sw data");
        chk("R7 stall on sw data", 32'(bub0), 32'd1);
        id_op = 3'd2; id_ra = 3'd0;
        check_all("R7 lw no B read");
        chk("R7 lw rb not a use", 32'(bub0), 32'd0);

        // R8: non-load in execute, empty decode
        id_op = 3'd0; id_ra = 3'd6; ex_op = 3'd0;
        check_all("R8 add in ex");
        chk("R8 add never stalls", 32'({pc0, if0, bub0}), 32'b110);
        ex_op = 3'd2; id_valid = 0;
        check_all("R8 empty decode");
        chk("R8 no stall empty decode", 32'(pc0), 32'd1);

        // Random mix, fixed seed (R3 R4 R5 R6 R7 R9 R10)
        void'($urandom(32'd370));
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #1;
            id_valid = 1'($urandom_range(0, 1)); id_op = 3'($urandom_range(0, 7));
            id_ra = 3'($urandom); id_rb = 3'($urandom);
            ex_valid = ($urandom_range(0, 7) != 0); ex_op = 3'($urandom_range(0, 7));
            ex_ra = 3'($urandom_range(0, 3)); ex_rb = 3'($urandom_range(0, 3));
            exmem_valid = 1'($urandom); exmem_op = 3'($urandom);
            exmem_rb = 3'($urandom_range(0, 3)); exmem_rd = 3'($urandom_range(0, 3));
            memwb_valid = 1'($urandom); memwb_op = 3'($urandom);
            memwb_rb = 3'($urandom_range(0, 3)); memwb_rd = 3'($urandom_range(0, 3));
            wbend_valid = 1'($urandom); wbend_op = 3'($urandom);
            wbend_rb = 3'($urandom_range(0, 3)); wbend_rd = 3'($urandom_range(0, 3));
            check_all("R3/R4/R5/R6/R7/R10 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule